// File: doc/BRIEF.md
# Frequency-Lock Drift Correction Controller

This block closes a slow correction loop around a free-running oscillator. It receives one frequency count per measurement period, with a valid strobe. One count LSB stands for 10 Hz. The block decides by itself whether the oscillator is being tuned or is resting. While resting and locked, it drives a width-modulated correction pulse toward an external integrator. The pulse is up when the reading is low and down when it is high, and its width is proportional to the error against a held reference.

The block tracks the change between successive counts. A change larger than a threshold means the operator is turning the dial. The block then drops lock and asks the integrator to go to mid-range. Once a run of identical readings shows the dial is still, the block locks again and takes the current count as the new target. No lock command exists; the loop is invisible to the user.

The default pulse scale is a simulation-friendly number of clock cycles per count LSB. In a real build, `TICKS_PER_LSB` is set to the cycle count of 2 ms, and `MAX_PULSE` is set below the count period.

Top module: `freq_lock_ctrl`

## Requirements
- R1: After reset, lock_o is 0, mid_o is 1, and up_o and dn_o are 0.
- R2: The first strobe after reset only records the count and is not compared, so it can neither count toward settling nor unlock.
- R3: A strobe whose count differs from the previous count by more than JUMP_THR LSBs (default 5, i.e. more than 50 Hz) clears lock_o and sets mid_o from the next cycle. It also ends any running pulse at once and starts no new one.
- R4: While unlocked, lock_o rises in the cycle after the strobe that completes SETTLE_N (default 3) consecutive zero-change comparisons. mid_o falls at the same time. That strobe's count becomes the reference.
- R5: While unlocked, a nonzero change within the threshold restarts the settling run from zero.
- R6: While locked, a count above the reference gives a dn_o pulse, and a count below gives an up_o pulse. The pulse starts in the cycle after the strobe and lasts |count-ref|*TICKS_PER_LSB cycles (default 8 per LSB).
- R7: The pulse width saturates at MAX_PULSE cycles (default 64).
- R8: A locked strobe with zero error produces no pulse, and up_o and dn_o are never high together.
- R9: A strobe arriving during a pulse replaces it with the width and polarity of the new error.
- R10: A change of exactly JUMP_THR LSBs keeps the lock.
- R11: While locked, the reference does not move, so errors are measured against the lock-time count and not the previous count.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| cnt_vld_i | input | 1 | One-cycle strobe marking a new count |
| cnt_i | input | COUNT_W | Frequency count, 10 Hz per LSB |
| up_o | output | 1 | Raise-frequency correction pulse |
| dn_o | output | 1 | Lower-frequency correction pulse |
| mid_o | output | 1 | Request to hold the control voltage at mid-range |
| lock_o | output | 1 | Loop locked |

## Verification
A wrong reference or stale previous count shows up as a pulse of the wrong width or polarity on the very next strobe, one cycle after it is sampled. Pulse widths are counted cycle by cycle to catch scaling and saturation faults. An off-by-one settling counter shows as lock_o rising one strobe early or late. This is checked both from reset and after a restarted run. A missing abort shows as correction cycles continuing past a tuning jump, which is visible on the first cycle after that strobe.

// File: rtl/flk_pkg.sv
package flk_pkg;
  typedef enum logic {
    ST_FREE = 1'b0,
    ST_HELD = 1'b1
  } lock_st_e;
endpackage

// File: rtl/flk_delta.sv
module flk_delta #(
  parameter int COUNT_W  = 24,
  parameter int JUMP_THR = 5,
  localparam int ERR_W   = COUNT_W + 1
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               vld_i,
  input  logic [COUNT_W-1:0] cnt_i,
  output logic               cmp_ok_o,
  output logic               jump_o,
  output logic               zero_o
);
  logic [COUNT_W-1:0] prev_q;
  logic               have_q;
  logic [ERR_W-1:0]   diff, mag;

  always_comb begin
    diff = {1'b0, cnt_i} - {1'b0, prev_q};
    mag  = diff[ERR_W-1] ? (~diff + 1'b1) : diff;
  end

  assign cmp_ok_o = have_q;
  assign jump_o   = have_q && (mag > ERR_W'(JUMP_THR));
  assign zero_o   = have_q && (diff == '0);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      prev_q <= '0;
      have_q <= 1'b0;
    end else if (vld_i) begin
      prev_q <= cnt_i;
      have_q <= 1'b1;
    end
  end

  AST_HAVE_AFTER_STROBE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    vld_i |=> cmp_ok_o); // R2
endmodule

// File: rtl/flk_lock.sv
module flk_lock
  import flk_pkg::*;
#(
  parameter int COUNT_W  = 24,
  parameter int SETTLE_N = 3,
  localparam int ERR_W   = COUNT_W + 1,
  localparam int SET_W   = $clog2(SETTLE_N + 1)
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               vld_i,
  input  logic [COUNT_W-1:0] cnt_i,
  input  logic               cmp_ok_i,
  input  logic               jump_i,
  input  logic               zero_i,
  output logic               lock_o,
  output logic               corr_vld_o,
  output logic               clear_o,
  output logic [ERR_W-1:0]   err_o
);
  lock_st_e           st_q;
  logic [SET_W-1:0]   settle_q;
  logic [COUNT_W-1:0] ref_q;
  logic               cmp_vld;

  assign cmp_vld    = vld_i && cmp_ok_i;
  assign lock_o     = (st_q == ST_HELD);
  assign clear_o    = cmp_vld && jump_i;
  assign corr_vld_o = cmp_vld && !jump_i && lock_o;
  assign err_o      = {1'b0, cnt_i} - {1'b0, ref_q};

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q     <= ST_FREE;
      settle_q <= '0;
      ref_q    <= '0;
    end else if (cmp_vld) begin
      if (jump_i) begin
        st_q     <= ST_FREE;
        settle_q <= '0;
      end else if (st_q == ST_FREE) begin
        if (!zero_i) begin
          settle_q <= '0;
        end else if (settle_q == SET_W'(SETTLE_N - 1)) begin
          st_q     <= ST_HELD;
          ref_q    <= cnt_i;
          settle_q <= '0;
        end else begin
          settle_q <= settle_q + 1'b1;
        end
      end
    end
  end

  AST_JUMP_UNLOCKS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (vld_i && cmp_ok_i && jump_i) |=> !lock_o); // R3
  AST_LOCK_ON_ZERO: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(lock_o) |-> $past(vld_i && zero_i && !jump_i)); // R4
  AST_REF_HELD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (lock_o && $past(lock_o)) |-> $stable(ref_q)); // R11
endmodule

// File: rtl/flk_pulse.sv
module flk_pulse #(
  parameter int ERR_W         = 25,
  parameter int TICKS_PER_LSB = 8,
  parameter int MAX_PULSE     = 64,
  localparam int PW           = $clog2(MAX_PULSE + 1),
  localparam int LIM          = MAX_PULSE / TICKS_PER_LSB,
  localparam int PROD_W       = ERR_W + 32
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             load_i,
  input  logic             clear_i,
  input  logic [ERR_W-1:0] err_i,
  output logic             up_o,
  output logic             dn_o
);
  logic [ERR_W-1:0]  mag;
  logic [PROD_W-1:0] prod;
  logic [PW-1:0]     width, cnt_q;
  logic              down_q;

  always_comb begin
    mag  = err_i[ERR_W-1] ? (~err_i + 1'b1) : err_i;
    prod = PROD_W'(mag) * PROD_W'(TICKS_PER_LSB);
    // saturate before the product can exceed the limit
    width = (mag > ERR_W'(LIM)) ? PW'(MAX_PULSE) : PW'(prod);
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q  <= '0;
      down_q <= 1'b0;
    end else if (clear_i) begin
      cnt_q <= '0;
    end else if (load_i) begin
      cnt_q  <= width;
      down_q <= !err_i[ERR_W-1];
    end else if (cnt_q != '0) begin
      cnt_q <= cnt_q - 1'b1;
    end
  end

  assign up_o = (cnt_q != '0) && !down_q;
  assign dn_o = (cnt_q != '0) && down_q;

  AST_UP_DN_EXCL: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(up_o && dn_o)); // R8
  AST_WIDTH_CAP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cnt_q <= PW'(MAX_PULSE)); // R7
  AST_CLEAR_STOPS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    clear_i |=> !(up_o || dn_o)); // R3
  AST_ZERO_IDLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (load_i && !clear_i && err_i == '0) |=> !(up_o || dn_o)); // R8
endmodule

// File: rtl/freq_lock_ctrl.sv
module freq_lock_ctrl #(
  parameter int COUNT_W       = 24,
  parameter int JUMP_THR      = 5,
  parameter int SETTLE_N      = 3,
  parameter int TICKS_PER_LSB = 8,
  parameter int MAX_PULSE     = 64,
  localparam int ERR_W        = COUNT_W + 1
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               cnt_vld_i,
  input  logic [COUNT_W-1:0] cnt_i,
  output logic               up_o,
  output logic               dn_o,
  output logic               mid_o,
  output logic               lock_o
);
  logic             cmp_ok, jump, zero;
  logic             corr_vld, clear;
  logic [ERR_W-1:0] err;

  flk_delta #(.COUNT_W(COUNT_W), .JUMP_THR(JUMP_THR)) i_delta (
    .clk_i, .rst_ni, .vld_i(cnt_vld_i), .cnt_i,
    .cmp_ok_o(cmp_ok), .jump_o(jump), .zero_o(zero)
  );

  flk_lock #(.COUNT_W(COUNT_W), .SETTLE_N(SETTLE_N)) i_lock (
    .clk_i, .rst_ni, .vld_i(cnt_vld_i), .cnt_i,
    .cmp_ok_i(cmp_ok), .jump_i(jump), .zero_i(zero),
    .lock_o, .corr_vld_o(corr_vld), .clear_o(clear), .err_o(err)
  );

  flk_pulse #(.ERR_W(ERR_W), .TICKS_PER_LSB(TICKS_PER_LSB), .MAX_PULSE(MAX_PULSE)) i_pulse (
    .clk_i, .rst_ni, .load_i(corr_vld), .clear_i(clear), .err_i(err),
    .up_o, .dn_o
  );

  assign mid_o = !lock_o;

  AST_NO_PULSE_FREE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!lock_o && !$past(lock_o)) |-> !(up_o || dn_o)); // R3
endmodule

// File: tb/test_freq_lock_ctrl.sv
module test_freq_lock_ctrl;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        vld = 1'b0;
  logic [23:0] cnt = '0;
  logic        up, dn, mid, lock;
  int checks = 0;
  int errors = 0;

  always #10 clk = ~clk;

  freq_lock_ctrl i_freq_lock_ctrl (
    .clk_i(clk), .rst_ni(rst_n), .cnt_vld_i(vld), .cnt_i(cnt),
    .up_o(up), .dn_o(dn), .mid_o(mid), .lock_o(lock)
  );

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  // drive one strobe, then count pulse cycles over a window
  task automatic strobe(input int v, output int nu, output int nd);
    nu = 0; nd = 0;
    cnt = 24'(v); vld = 1'b1;
    @(negedge clk); vld = 1'b0;
    for (int i = 0; i < 80; i++) begin
      if (up) nu++;
      if (dn) nd++;
      if (up && dn) check(0, "R8 both high", 1, 0);
      @(negedge clk);
    end
  endtask

  task automatic relock(input int v);
    int nu, nd;
    for (int i = 0; i < 4; i++) strobe(v, nu, nd);
    check(lock == 1'b1, "R4 relock", int'(lock), 1);
  endtask

  task automatic t_reset;
    check(lock == 1'b0, "R1 lock", int'(lock), 0);
    check(mid == 1'b1, "R1 mid", int'(mid), 1);
    check(!up && !dn, "R1 pulses", int'(up | dn), 0);
  endtask

  task automatic t_first_lock;
    int nu, nd;
    for (int i = 0; i < 3; i++) strobe(500, nu, nd);
    check(lock == 1'b0, "R2 first strobe not compared", int'(lock), 0);
    strobe(500, nu, nd);
    check(lock == 1'b1, "R4 lock after three zeros", int'(lock), 1);
    check(mid == 1'b0, "R4 mid drops", int'(mid), 0);
    check(nu == 0 && nd == 0, "R8 no pulse on zero error", nu + nd, 0);
  endtask

  task automatic t_correct;
    int nu, nd;
    strobe(503, nu, nd);
    check(nd == 24 && nu == 0, "R6 high reading gives down", nd, 24);
    strobe(498, nu, nd);
    check(nu == 16 && nd == 0, "R6 low reading gives up", nu, 16);
    check(lock == 1'b1, "R10 change of threshold keeps lock", int'(lock), 1);
    strobe(500, nu, nd);
    check(nu == 0 && nd == 0, "R8 zero error idle", nu + nd, 0);
    strobe(502, nu, nd);
    check(nd == 16, "R11 first step", nd, 16);
    strobe(504, nu, nd);
    check(nd == 32, "R11 measured from reference", nd, 32);
  endtask

  task automatic t_saturate;
    int nu, nd;
    strobe(509, nu, nd);
    check(nd == 64, "R7 saturate err 9", nd, 64);
    strobe(512, nu, nd);
    check(nd == 64, "R7 saturate err 12", nd, 64);
  endtask

  task automatic t_jump;
    int nu, nd;
    strobe(518, nu, nd);
    check(lock == 1'b0, "R3 jump unlocks", int'(lock), 0);
    check(mid == 1'b1, "R3 mid raised", int'(mid), 1);
    check(nu == 0 && nd == 0, "R3 no pulse on jump", nu + nd, 0);
  endtask

  task automatic t_abort;
    int nu, nd, n;
    relock(800);
    n = 0;
    cnt = 24'(804); vld = 1'b1;
    @(negedge clk); vld = 1'b0;
    repeat (4) begin if (dn) n++; @(negedge clk); end
    check(n == 4, "R6 pulse running", n, 4);
    strobe(820, nu, nd);
    check(nd == 0 && nu == 0, "R3 jump aborts pulse", nd, 0);
    check(lock == 1'b0, "R3 unlocked after abort", int'(lock), 0);
  endtask

  task automatic t_restart;
    int nu, nd, n;
    relock(900);
    n = 0;
    cnt = 24'(903); vld = 1'b1;
    @(negedge clk); vld = 1'b0;
    repeat (3) begin if (dn) n++; @(negedge clk); end
    if (dn) n++;
    strobe(901, nu, nd);
    n += nd;
    check(n == 12 && nu == 0, "R9 new strobe replaces pulse", n, 12);
  endtask

  task automatic t_settle_reset;
    int nu, nd;
    strobe(700, nu, nd);
    strobe(700, nu, nd);
    strobe(700, nu, nd);
    strobe(701, nu, nd);
    check(lock == 1'b0, "R5 small change while free", int'(lock), 0);
    strobe(701, nu, nd);
    strobe(701, nu, nd);
    check(lock == 1'b0, "R5 run restarted", int'(lock), 0);
    strobe(701, nu, nd);
    check(lock == 1'b1, "R5 lock after fresh run", int'(lock), 1);
    strobe(702, nu, nd);
    check(nd == 8, "R4 reference is settling count", nd, 8);
  endtask

  initial begin
    #(20 * 200000);
    errors++;
    $display("FAIL watchdog: actual timeout expected finish");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_first_lock();
    t_correct();
    t_saturate();
    t_jump();
    t_abort();
    t_restart();
    t_settle_reset();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule